// File: doc/BRIEF.md
# Multi-Standard Video Test Pattern Generator

This block drives a serial digital video transmitter with a continuous 20-bit parallel word stream, one word per clock. It walks a raster of lines and samples and places timing reference sequences at the line boundaries. The picture area is filled with one of three test patterns: full-amplitude colour bars, colour bars scaled to three quarters, or a two-level pathological checkfield. Three video formats are available: a standard-definition interleaved 10-bit stream (270 Mb/s class), an interlaced 1080-line high-definition stream (1.485 Gb/s class) and a progressive 1080-line stream (2.970 Gb/s class). Alongside each word it gives frame-start, line-start and active-video markers.

The format and pattern are static control inputs. They are taken on reset and then only at each frame boundary, so a change made mid-frame never tears the picture. The raster geometry for each format is set by parameters: words per line, active words per line, lines per frame, vertical blanking lines per field, and whether the format is interlaced. A bench can therefore use a very small raster. CRC words, line-number words, ancillary data, scrambling and serialisation are not part of this block.

Top module: `vid_pattern_gen`

## Requirements
- R1: While `rst` is high, every output is 0. After `rst` falls, the first word out is word 0 of line 1, which is the first word of an end-of-line timing sequence, and `frame_start` is high with it.
- R2: Format code `std_sel` is decoded as 00 = SD, 01 = HD, 10 = HD, 11 = progressive 3G. A frame lasts exactly LINE_W × LINES words of the format latched for that frame. Lines are numbered from 1 and words from 0.
- R3: Each line holds two 4-word timing sequences. The end-of-line sequence sits at words 0 to 3. The start-of-picture sequence sits at words LINE_W−ACT_W−4 to LINE_W−ACT_W−1. Each sequence carries the values 0x3FF, 0x000, 0x000, then a status word. In HD and 3G the same value is on bits [19:10] and on bits [9:0].
- R4: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}, MSB first, where H = 1 in the end-of-line sequence and H = 0 in the start-of-picture sequence.
- R5: In an interlaced format, lines 1 to floor(LINES/2) form field 0 (F = 0) and the remaining lines form field 1 (F = 1). A progressive format has a single field with F = 0. V = 1 for the first VBLANK lines of each field and V = 0 for the rest.
- R6: Every word that is neither a timing word nor a picture sample is blanking: chroma 0x200 and luma 0x040. This includes the whole picture region of V = 1 lines.
- R7: In SD, bits [19:10] are always 0. Even words carry chroma and odd words carry luma on bits [9:0]. Picture samples follow the order Cb, Y, Cr, Y, starting at the first active word.
- R8: In HD and 3G, luma is on bits [19:10] and chroma on bits [9:0]. Chroma is Cb on even active words and Cr on odd ones, counted from the first active word.
- R9: With `pat_check` = 0 and `amp_full` = 1, the active words split into eight bars of ACT_W/8 words. Left to right, the bars and their (Y, Cb, Cr) values are: white (940,512,512), yellow (877,64,553), cyan (754,615,64), green (691,167,105), magenta (313,857,919), red (250,409,960), blue (127,960,471), black (64,512,512).
- R10: With `pat_check` = 0 and `amp_full` = 0, each bar component becomes base + floor(0.75·(value − base) + 0.5). The base is 64 for luma and 512 for chroma.
- R11: With `pat_check` = 1, whatever the value of `amp_full`, the picture is a checkfield. In each field, the first floor(A/2) of its A active lines carry chroma 0x300 and luma 0x198. The remaining active lines carry chroma 0x200 and luma 0x110.
- R12: A change on `std_sel`, `pat_check` or `amp_full` affects nothing until the first word of the next frame.
- R13: `line_start` is high on word 0 of each line. `frame_start` is high only on word 0 of line 1. `active_video` is high exactly on picture words of V = 0 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset; restarts the raster and latches the controls |
| std_sel | input | 2 | Video format code |
| pat_check | input | 1 | 1 selects the checkfield, 0 selects colour bars |
| amp_full | input | 1 | Colour bar amplitude: 1 full, 0 three quarters |
| vid_data | output | 20 | Parallel video word |
| frame_start | output | 1 | Marks the first word of a frame |
| line_start | output | 1 | Marks the first word of a line |
| active_video | output | 1 | Marks picture samples |

## Verification
The hardest behaviour to reach is a control change that lands in the middle of a frame. Reaching it takes a run that has already passed reset and has stepped partway through the raster. The stimulus flips format and pattern inputs at cycle counts that fall inside a frame, including a format change that alters line length. A mid-frame reset with new control values is also applied, to confirm that the old geometry finishes its frame, the new one starts exactly at the wrap, and reset restarts at once. An odd line count in the interlaced HD format gives fields of unequal length, which exercises the field split and the checkfield half-line arithmetic.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

    localparam int SMP_W = 10;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        STD_SD = 2'd0,
        STD_HD = 2'd1,
        STD_3G = 2'd2
    } vstd_e;

    typedef enum logic [1:0] {
        PAT_BAR_FULL = 2'd0,
        PAT_BAR_75   = 2'd1,
        PAT_CHECK    = 2'd2
    } vpat_e;

    typedef struct packed {
        logic [SMP_W-1:0] y;
        logic [SMP_W-1:0] cb;
        logic [SMP_W-1:0] cr;
    } ycc_t;

    // Raster position decoded for one word, consumed by the sample builder
    typedef struct packed {
        vstd_e      fmt;
        vpat_e      pat;
        logic       f_bit;
        logic       v_bit;
        logic       in_eav;
        logic       in_sav;
        logic       in_act;
        logic [1:0] trs_pos;
        logic [1:0] act_phase;
        logic [2:0] bar_idx;
        logic       chk_upper;
        logic       word_odd;
        logic       frame_head;
        logic       line_head;
    } raster_t;

    localparam logic [SMP_W-1:0] BLANK_Y  = 10'h040;
    localparam logic [SMP_W-1:0] BLANK_C  = 10'h200;
    localparam logic [SMP_W-1:0] CHK_UP_C = 10'h300;
    localparam logic [SMP_W-1:0] CHK_UP_Y = 10'h198;
    localparam logic [SMP_W-1:0] CHK_LO_C = 10'h200;
    localparam logic [SMP_W-1:0] CHK_LO_Y = 10'h110;
    localparam logic [SMP_W-1:0] TRS_ONES = 10'h3FF;

    function automatic vstd_e decode_std(input logic [1:0] code);
        case (code)
            2'b00:   return STD_SD;
            2'b11:   return STD_3G;
            default: return STD_HD;
        endcase
    endfunction

    function automatic vpat_e decode_pat(input logic chk, input logic full);
        if (chk)       return PAT_CHECK;
        else if (full) return PAT_BAR_FULL;
        else           return PAT_BAR_75;
    endfunction

    function automatic logic [SMP_W-1:0] make_xyz(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic ycc_t bar_full(input logic [2:0] idx);
        case (idx)
            3'd0:    return '{y: 10'd940, cb: 10'd512, cr: 10'd512};
            3'd1:    return '{y: 10'd877, cb: 10'd64,  cr: 10'd553};
            3'd2:    return '{y: 10'd754, cb: 10'd615, cr: 10'd64};
            3'd3:    return '{y: 10'd691, cb: 10'd167, cr: 10'd105};
            3'd4:    return '{y: 10'd313, cb: 10'd857, cr: 10'd919};
            3'd5:    return '{y: 10'd250, cb: 10'd409, cr: 10'd960};
            3'd6:    return '{y: 10'd127, cb: 10'd960, cr: 10'd471};
            default: return '{y: 10'd64,  cb: 10'd512, cr: 10'd512};
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] scale_75(input logic [SMP_W-1:0] val,
                                                  input logic [SMP_W-1:0] base);
        int diff;
        int res;
        diff = int'(val) - int'(base);
        res  = int'(base) + ((diff * 3 + 2) >>> 2);
        return res[SMP_W-1:0];
    endfunction

    function automatic ycc_t bar_75(input logic [2:0] idx);
        ycc_t b;
        b = bar_full(idx);
        return '{y: scale_75(b.y, BLANK_Y), cb: scale_75(b.cb, BLANK_C), cr: scale_75(b.cr, BLANK_C)};
    endfunction

endpackage

// File: rtl/vpg_raster.sv
module vpg_raster
    import vpg_pkg::*;
#(
    parameter int SD_LINE_W = 1716,
    parameter int SD_ACT_W  = 1440,
    parameter int SD_LINES  = 525,
    parameter int SD_VBLANK = 19,
    parameter bit SD_ILACE  = 1'b1,
    parameter int HD_LINE_W = 2200,
    parameter int HD_ACT_W  = 1920,
    parameter int HD_LINES  = 1125,
    parameter int HD_VBLANK = 20,
    parameter bit HD_ILACE  = 1'b1,
    parameter int G3_LINE_W = 2200,
    parameter int G3_ACT_W  = 1920,
    parameter int G3_LINES  = 1125,
    parameter int G3_VBLANK = 41,
    parameter bit G3_ILACE  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] std_code,
    input  logic       pat_check,
    input  logic       amp_full,
    output raster_t    rs
);

    vstd_e            std_q;
    vpat_e            pat_q;
    logic [CNT_W-1:0] word_q;
    logic [CNT_W-1:0] line_q;
    logic [CNT_W-1:0] bar_cnt_q;
    logic [2:0]       bar_q;

    logic [CNT_W-1:0] g_line_w, g_act_w, g_lines, g_vblank;
    logic             g_ilace;

    always_comb begin
        case (std_q)
            STD_SD: begin
                g_line_w = CNT_W'(SD_LINE_W);
                g_act_w  = CNT_W'(SD_ACT_W);
                g_lines  = CNT_W'(SD_LINES);
                g_vblank = CNT_W'(SD_VBLANK);
                g_ilace  = SD_ILACE;
            end
            STD_3G: begin
                g_line_w = CNT_W'(G3_LINE_W);
                g_act_w  = CNT_W'(G3_ACT_W);
                g_lines  = CNT_W'(G3_LINES);
                g_vblank = CNT_W'(G3_VBLANK);
                g_ilace  = G3_ILACE;
            end
            default: begin
                g_line_w = CNT_W'(HD_LINE_W);
                g_act_w  = CNT_W'(HD_ACT_W);
                g_lines  = CNT_W'(HD_LINES);
                g_vblank = CNT_W'(HD_VBLANK);
                g_ilace  = HD_ILACE;
            end
        endcase
    end

    logic [CNT_W-1:0] act_start, sav_start, bar_w, half;
    logic [CNT_W-1:0] fline, flen, act_lines, apos;
    logic             second_field, v_now, in_eav, in_sav, in_act;
    logic             last_word, last_line, wrap;

    always_comb begin
        act_start    = g_line_w - g_act_w;
        sav_start    = act_start - CNT_W'(4);
        bar_w        = g_act_w >> 3;
        half         = g_ilace ? (g_lines >> 1) : g_lines;
        second_field = g_ilace && (line_q > half);
        fline        = second_field ? (line_q - half) : line_q;
        flen         = second_field ? (g_lines - half) : half;
        v_now        = (fline <= g_vblank);
        act_lines    = flen - g_vblank;
        apos         = fline - g_vblank - CNT_W'(1);
        in_eav       = (word_q < CNT_W'(4));
        in_sav       = (word_q >= sav_start) && (word_q < act_start);
        in_act       = (word_q >= act_start);
        last_word    = (word_q == g_line_w - CNT_W'(1));
        last_line    = (line_q == g_lines);
        wrap         = last_word && last_line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            line_q <= CNT_W'(1);
            std_q  <= decode_std(std_code);
            pat_q  <= decode_pat(pat_check, amp_full);
        end else if (last_word) begin
            word_q <= '0;
            if (last_line) begin
                line_q <= CNT_W'(1);
                std_q  <= decode_std(std_code);
                pat_q  <= decode_pat(pat_check, amp_full);
            end else begin
                line_q <= line_q + CNT_W'(1);
            end
        end else begin
            word_q <= word_q + CNT_W'(1);
        end
    end

    // Bar tracker: width counter instead of a divide on the word index
    always_ff @(posedge clk) begin
        if (rst) begin
            bar_cnt_q <= '0;
            bar_q     <= '0;
        end else if (word_q == act_start - CNT_W'(1)) begin
            bar_cnt_q <= '0;
            bar_q     <= '0;
        end else if (in_act) begin
            if (bar_cnt_q == bar_w - CNT_W'(1)) begin
                bar_cnt_q <= '0;
                bar_q     <= bar_q + 3'd1;
            end else begin
                bar_cnt_q <= bar_cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        rs.fmt        = std_q;
        rs.pat        = pat_q;
        rs.f_bit      = second_field;
        rs.v_bit      = v_now;
        rs.in_eav     = in_eav;
        rs.in_sav     = in_sav;
        rs.in_act     = in_act;
        rs.trs_pos    = in_eav ? word_q[1:0] : 2'(word_q - sav_start);
        rs.act_phase  = 2'(word_q - act_start);
        rs.bar_idx    = bar_q;
        rs.chk_upper  = (apos < (act_lines >> 1));
        rs.word_odd   = word_q[0];
        rs.frame_head = (word_q == '0) && (line_q == CNT_W'(1));
        rs.line_head  = (word_q == '0);
    end

    AST_WORD_IN_LINE: assert property (@(posedge clk) disable iff (rst) word_q < g_line_w); // R2
    AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (rst) (line_q >= CNT_W'(1)) && (line_q <= g_lines)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst) !wrap |=> ($stable(std_q) && $stable(pat_q))); // R12

endmodule

// File: rtl/vpg_sample.sv
module vpg_sample
    import vpg_pkg::*;
(
    input  raster_t     rs,
    output logic [19:0] word,
    output logic        act
);

    ycc_t             bar;
    logic [SMP_W-1:0] y_v, c_v, trs_v;
    logic             is_trs, cr_sel, sd_mode;

    always_comb begin
        sd_mode = (rs.fmt == STD_SD);
        bar     = (rs.pat == PAT_BAR_75) ? bar_75(rs.bar_idx) : bar_full(rs.bar_idx);
        cr_sel  = sd_mode ? rs.act_phase[1] : rs.act_phase[0];
        act     = rs.in_act && !rs.v_bit;

        if (!act) begin
            y_v = BLANK_Y;
            c_v = BLANK_C;
        end else if (rs.pat == PAT_CHECK) begin
            y_v = rs.chk_upper ? CHK_UP_Y : CHK_LO_Y;
            c_v = rs.chk_upper ? CHK_UP_C : CHK_LO_C;
        end else begin
            y_v = bar.y;
            c_v = cr_sel ? bar.cr : bar.cb;
        end

        is_trs = rs.in_eav || rs.in_sav;
        case (rs.trs_pos)
            2'd0:    trs_v = TRS_ONES;
            2'd3:    trs_v = make_xyz(rs.f_bit, rs.v_bit, rs.in_eav);
            default: trs_v = '0;
        endcase

        if (sd_mode) begin
            word[19:10] = '0;
            word[9:0]   = is_trs ? trs_v : (rs.word_odd ? y_v : c_v);
        end else begin
            word[19:10] = is_trs ? trs_v : y_v;
            word[9:0]   = is_trs ? trs_v : c_v;
        end
    end

endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen
    import vpg_pkg::*;
#(
    parameter int SD_LINE_W = 1716,
    parameter int SD_ACT_W  = 1440,
    parameter int SD_LINES  = 525,
    parameter int SD_VBLANK = 19,
    parameter bit SD_ILACE  = 1'b1,
    parameter int HD_LINE_W = 2200,
    parameter int HD_ACT_W  = 1920,
    parameter int HD_LINES  = 1125,
    parameter int HD_VBLANK = 20,
    parameter bit HD_ILACE  = 1'b1,
    parameter int G3_LINE_W = 2200,
    parameter int G3_ACT_W  = 1920,
    parameter int G3_LINES  = 1125,
    parameter int G3_VBLANK = 41,
    parameter bit G3_ILACE  = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  std_sel,
    input  logic        pat_check,
    input  logic        amp_full,
    output logic [19:0] vid_data,
    output logic        frame_start,
    output logic        line_start,
    output logic        active_video
);

    raster_t     rs;
    logic [19:0] word_c;
    logic        act_c;

    vpg_raster #(
        .SD_LINE_W(SD_LINE_W), .SD_ACT_W(SD_ACT_W), .SD_LINES(SD_LINES),
        .SD_VBLANK(SD_VBLANK), .SD_ILACE(SD_ILACE),
        .HD_LINE_W(HD_LINE_W), .HD_ACT_W(HD_ACT_W), .HD_LINES(HD_LINES),
        .HD_VBLANK(HD_VBLANK), .HD_ILACE(HD_ILACE),
        .G3_LINE_W(G3_LINE_W), .G3_ACT_W(G3_ACT_W), .G3_LINES(G3_LINES),
        .G3_VBLANK(G3_VBLANK), .G3_ILACE(G3_ILACE)
    ) u_raster (
        .clk      (clk),
        .rst      (rst),
        .std_code (std_sel),
        .pat_check(pat_check),
        .amp_full (amp_full),
        .rs       (rs)
    );

    vpg_sample u_sample (
        .rs  (rs),
        .word(word_c),
        .act (act_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_data     <= '0;
            frame_start  <= 1'b0;
            line_start   <= 1'b0;
            active_video <= 1'b0;
        end else begin
            vid_data     <= word_c;
            frame_start  <= rs.frame_head;
            line_start   <= rs.line_head;
            active_video <= act_c;
        end
    end

    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst) frame_start |-> line_start); // R13
    AST_EAV_LEADS: assert property (@(posedge clk) disable iff (rst) line_start |-> (vid_data[9:0] == 10'h3FF)); // R3
    AST_PIC_NOT_TRS: assert property (@(posedge clk) disable iff (rst) active_video |-> ((vid_data[9:0] != 10'h3FF) && (vid_data[9:0] != 10'h000))); // R3
    AST_SD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (rs.fmt == STD_SD) |=> (vid_data[19:10] == 10'h000)); // R7

endmodule

// File: tb/sim_vid_pattern_gen.sv
`timescale 1ns/1ps
module sim_vid_pattern_gen;

    localparam int SDW = 48, SDA = 32, SDL = 10, SDV = 2;
    localparam bit SDI = 1'b1;
    localparam int HDW = 52, HDA = 32, HDL = 11, HDV = 2;
    localparam bit HDI = 1'b1;
    localparam int GW  = 44, GA  = 32, GL  = 8,  GV  = 1;
    localparam bit GI  = 1'b0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  std_sel = 2'b00;
    logic        pat_check = 1'b0;
    logic        amp_full = 1'b1;
    logic [19:0] vid_data;
    logic        frame_start, line_start, active_video;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vid_pattern_gen #(
        .SD_LINE_W(SDW), .SD_ACT_W(SDA), .SD_LINES(SDL), .SD_VBLANK(SDV), .SD_ILACE(SDI),
        .HD_LINE_W(HDW), .HD_ACT_W(HDA), .HD_LINES(HDL), .HD_VBLANK(HDV), .HD_ILACE(HDI),
        .G3_LINE_W(GW),  .G3_ACT_W(GA),  .G3_LINES(GL),  .G3_VBLANK(GV),  .G3_ILACE(GI)
    ) u0 (
        .clk(clk), .rst(rst), .std_sel(std_sel), .pat_check(pat_check), .amp_full(amp_full),
        .vid_data(vid_data), .frame_start(frame_start), .line_start(line_start),
        .active_video(active_video)
    );

    // ---------------- reference model ----------------
    function automatic int fmt_of(input logic [1:0] code);
        if (code == 2'b00) return 0;
        if (code == 2'b11) return 2;
        return 1;
    endfunction

    task automatic geom(input int f, output int lw, output int aw, output int nl,
                        output int vb, output bit il);
        if (f == 0)      begin lw = SDW; aw = SDA; nl = SDL; vb = SDV; il = SDI; end
        else if (f == 1) begin lw = HDW; aw = HDA; nl = HDL; vb = HDV; il = HDI; end
        else             begin lw = GW;  aw = GA;  nl = GL;  vb = GV;  il = GI;  end
    endtask

    task automatic bar_vals(input int b, output int y, output int cb, output int cr);
        case (b)
            0: begin y = 940; cb = 512; cr = 512; end
            1: begin y = 877; cb = 64;  cr = 553; end
            2: begin y = 754; cb = 615; cr = 64;  end
            3: begin y = 691; cb = 167; cr = 105; end
            4: begin y = 313; cb = 857; cr = 919; end
            5: begin y = 250; cb = 409; cr = 960; end
            6: begin y = 127; cb = 960; cr = 471; end
            default: begin y = 64; cb = 512; cr = 512; end
        endcase
    endtask

    function automatic int three_quarter(input int v, input int base);
        real r;
        r = $floor((v - base) * 0.75 + 0.5);
        return base + $rtoi(r);
    endfunction

    task automatic model_word(input int f, input bit chk, input bit full, input int ln, input int wd,
                              output logic [19:0] d, output bit fs, output bit ls, output bit av,
                              output string tag);
        int lw, aw, nl, vb, half, fl, flen, astart, sstart, ai, y, cb, cr, ch, pos, c;
        int fb, vbit, h, xyz;
        bit il, trs;
        geom(f, lw, aw, nl, vb, il);
        half = il ? nl / 2 : nl;
        if (ln > half) begin fl = ln - half; flen = nl - half; fb = 1; end
        else           begin fl = ln;        flen = half;      fb = 0; end
        vbit   = (fl <= vb) ? 1 : 0;
        astart = lw - aw;
        sstart = astart - 4;
        fs = (ln == 1 && wd == 0);
        ls = (wd == 0);
        av = (wd >= astart) && (vbit == 0);
        trs = (wd < 4) || (wd >= sstart && wd < astart);
        c = 0; y = 64; ch = 512;
        if (trs) begin
            h   = (wd < 4) ? 1 : 0;
            pos = (h == 1) ? wd : wd - sstart;
            xyz = 512 + fb * 256 + vbit * 128 + h * 64 + (vbit ^ h) * 32 + (fb ^ h) * 16
                  + (fb ^ vbit) * 8 + (fb ^ vbit ^ h) * 4;
            c   = (pos == 0) ? 1023 : ((pos == 3) ? xyz : 0);
            tag = (pos == 3) ? "R4 R5" : "R3";
        end else if (av) begin
            ai = wd - astart;
            if (chk) begin
                if ((fl - vb - 1) < (flen - vb) / 2) begin y = 'h198; cb = 'h300; end
                else                                 begin y = 'h110; cb = 'h200; end
                cr  = cb;
                tag = "R11";
            end else begin
                bar_vals(ai / (aw / 8), y, cb, cr);
                if (!full) begin
                    y  = three_quarter(y, 64);
                    cb = three_quarter(cb, 512);
                    cr = three_quarter(cr, 512);
                    tag = "R10";
                end else tag = "R9";
            end
            if (f == 0) ch = ((ai % 4) == 2) ? cr : cb;
            else        ch = ((ai % 2) == 1) ? cr : cb;
        end else begin
            tag = "R6";
        end
        if (f == 0) begin
            d = {10'd0, 10'(trs ? c : (((wd % 2) == 1) ? y : ch))};
            tag = {tag, " R7"};
        end else begin
            d = {10'(trs ? c : y), 10'(trs ? c : ch)};
            tag = {tag, " R8"};
        end
    endtask

    int          m_fmt, m_line, m_word;
    bit          m_chk, m_full;
    logic [19:0] e_data = '0;
    bit          e_fs = 1'b0, e_ls = 1'b0, e_av = 1'b0;
    string       e_tag = "R1";
    int          e_len = 0;
    bit          first_word = 1'b0;

    always @(posedge clk) begin
        int lw, aw, nl, vb;
        bit il;
        if (rst) begin
            m_line = 1; m_word = 0;
            m_fmt  = fmt_of(std_sel); m_chk = pat_check; m_full = amp_full;
            e_data = '0; e_fs = 1'b0; e_ls = 1'b0; e_av = 1'b0;
            e_tag  = "R1";
            first_word = 1'b1;
        end else begin
            model_word(m_fmt, m_chk, m_full, m_line, m_word, e_data, e_fs, e_ls, e_av, e_tag);
            if (first_word) e_tag = {e_tag, " R1"};
            first_word = 1'b0;
            if (fmt_of(std_sel) != m_fmt || pat_check != m_chk || amp_full != m_full)
                e_tag = {e_tag, " R12"};
            geom(m_fmt, lw, aw, nl, vb, il);
            if (e_fs) e_len = lw * nl;
            if (m_word == lw - 1) begin
                m_word = 0;
                if (m_line == nl) begin
                    m_line = 1;
                    m_fmt  = fmt_of(std_sel); m_chk = pat_check; m_full = amp_full;
                end else m_line = m_line + 1;
            end else m_word = m_word + 1;
        end
    end

    // ---------------- comparison, away from the active edge ----------------
    int cyc = 0;
    int prev_len = 0;
    bit fs_seen = 1'b0;

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (vid_data !== e_data) begin
                errors++;
                $display("FAIL %s data: actual=%h expected=%h", e_tag, vid_data, e_data);
            end
            checks++;
            if (frame_start !== e_fs || line_start !== e_ls || active_video !== e_av) begin
                errors++;
                $display("FAIL R13 %s markers fs/ls/av: actual=%b%b%b expected=%b%b%b",
                         e_tag, frame_start, line_start, active_video, e_fs, e_ls, e_av);
            end
            if (rst) begin
                fs_seen = 1'b0;
                cyc = 0;
            end else begin
                cyc++;
                if (frame_start === 1'b1) begin
                    if (fs_seen) begin
                        checks++;
                        if (cyc != prev_len) begin
                            errors++;
                            $display("FAIL R2 frame length: actual=%0d expected=%0d", cyc, prev_len);
                        end
                    end
                    fs_seen  = 1'b1;
                    cyc      = 0;
                    prev_len = e_len;
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        rst = 1'b0;
        // SD: full bars, then 75% requested mid-frame, then checkfield
        run(300);  amp_full = 1'b0;
        run(700);  pat_check = 1'b1;
        run(700);
        // HD (code 01), format change lands mid-frame
        std_sel = 2'b01; pat_check = 1'b0; amp_full = 1'b1;
        run(900);  amp_full = 1'b0;
        run(800);  pat_check = 1'b1;
        run(800);
        // HD through code 10
        std_sel = 2'b10; pat_check = 1'b0; amp_full = 1'b1;
        run(700);
        // progressive 3G
        std_sel = 2'b11;
        run(800);  amp_full = 1'b0;
        run(600);  pat_check = 1'b1; amp_full = 1'b1;
        run(600);
        // reset in the middle of a frame with new controls
        run(137);
        rst = 1'b1; std_sel = 2'b01; pat_check = 1'b0; amp_full = 1'b1;
        run(2);
        rst = 1'b0;
        run(900);
        std_sel = 2'b00; pat_check = 1'b1;
        run(900);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule